// File: doc/BRIEF.md
# Register Rename Unit with Flush Recovery

This block gives an out-of-order core's front end one rename slot per cycle. Each request carries two source register numbers and one destination register number. For each source, the unit returns the physical tag that the speculative map currently holds. For a destination, it hands out the oldest tag in a circular free list. Register 0 is hard-wired to physical tag 0: it never takes a new tag and never waits. When an instruction retires, the core reports the retiring destination and its physical tag. The unit then writes that pair into a separate committed map. The tag that the committed map held before for that register goes to the tail of the free list.

A flush throws away all unretired work in one cycle. The speculative map is overwritten by the committed map, and this copy includes a retirement that happens in the same cycle. The free list's allocation pointer moves back to a commit-side pointer, which advances once for every retiring writer. As a result, every tag handed to a discarded instruction becomes free again, in its original order. When no tag is free, a request that needs one is stalled and takes nothing.

After reset, the free list is seeded one entry per cycle by a two-state controller. In FL_FILL, the controller writes tags 16 to 47 in order, one per cycle, at the tail. It moves FL_FILL → FL_RUN in the cycle it writes the last seed. It stays in FL_RUN until the next reset. Every request is stalled while the controller is in FL_FILL.

Top module: `rn_rename_unit`

## Requirements
- R1: For the 32 cycles after reset, any valid request sees `ren_stall` high. After that, every architectural register i reads as physical tag i.
- R2: Source tags come from the speculative map as it stood before the edge. An instruction whose source equals its own destination reads the old tag, and the next request sees the new one.
- R3: Destination tags come from the free list in FIFO order. After reset they are 16, 17, … 47, and an accepted writer never receives tag 0.
- R4: Architectural register 0 always reads as tag 0. A request with destination 0 gets `ren_dst_tag` 0, allocates nothing and never stalls on an empty free list.
- R5: When the free list is empty, a valid request with a non-zero destination raises `ren_stall`, drops `ren_accept` and allocates nothing.
- R6: A retirement with a non-zero destination writes `ret_dst_tag` into the committed map. The tag previously committed for that register is appended to the free list and is handed out after all the tags already free.
- R7: From the cycle after `flush`, sources read the committed map, including a retirement in the same cycle as the flush.
- R8: After a flush, the next destination tag handed out is the one given to the oldest unretired writer. It is followed by the rest of that writer's successors and then the tags that were already free.
- R9: `ren_accept` equals `ren_valid` and not `ren_stall` and not `flush`. A request in a flush cycle changes neither map nor free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_src1_arch | input | 4 | First source register number |
| ren_src2_arch | input | 4 | Second source register number |
| ren_dst_arch | input | 4 | Destination register number (0 = none) |
| ren_src1_tag | output | 6 | Physical tag of first source |
| ren_src2_tag | output | 6 | Physical tag of second source |
| ren_dst_tag | output | 6 | Tag allocated to the destination (0 for register 0) |
| ren_stall | output | 1 | Request cannot be taken this cycle |
| ren_accept | output | 1 | Request taken at this edge |
| ret_valid | input | 1 | An instruction retires |
| ret_dst_arch | input | 4 | Retiring destination register number |
| ret_dst_tag | input | 6 | Tag the retiring instruction was given |
| flush | input | 1 | Discard all unretired instructions |

## Verification
The assertions rely on the core retiring writers strictly in the order they were renamed, each with the exact tag it received. They also rely on the core never retiring more writers than are in flight and on nothing retiring or flushing while the free list is still seeding. The bench keeps these rules with an in-order queue of renamed writers. It retires only the head of that queue, clears the queue on every flush, and holds all traffic until the seeding window has passed. The random phase also draws each retirement from that queue, so that mixed traffic stays inside what the checks assume.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
    // Free-list controller states
    typedef enum logic [0:0] {
        FL_FILL = 1'b0,   // seeding the free list after reset
        FL_RUN  = 1'b1    // normal allocate / release operation
    } fl_state_e;
endpackage

// File: rtl/rn_map_table.sv
`timescale 1ns/1ps
// One architectural-to-physical map. Bulk load happens first, then the single
// write port lands on top of it, so a flush and a retirement in one cycle compose.
module rn_map_table #(
    parameter int NUM_ARCH = 16,
    parameter int TAG_W    = 6,
    parameter int AIDX_W   = $clog2(NUM_ARCH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [AIDX_W-1:0]                wr_idx,
    input  logic [TAG_W-1:0]                 wr_tag,
    input  logic                             load_en,
    input  logic [NUM_ARCH-1:0][TAG_W-1:0]   load_img,
    output logic [NUM_ARCH-1:0][TAG_W-1:0]   img_q
);
    logic [NUM_ARCH-1:0][TAG_W-1:0] img_d;

    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
        if (g == 0) begin : g_zero
            // register 0 is pinned: no write port reaches it
            assign img_d[g] = load_en ? load_img[g] : img_q[g];
        end else begin : g_norm
            assign img_d[g] = (wr_en && (wr_idx == AIDX_W'(g))) ? wr_tag
                            : (load_en ? load_img[g] : img_q[g]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) img_q[i] <= TAG_W'(i);
        end else begin
            img_q <= img_d;
        end
    end

    // R4: entry 0 never leaves physical tag 0
    p_zero_pinned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        img_q[0] == '0)
        else $error("map entry 0 lost tag 0");
endmodule

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
// Circular free list with a speculative head, a commit-side head checkpoint
// and a tail. Seeded one entry per cycle after reset.
module rn_free_list
    import rn_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int TAG_W    = 6,
    parameter int BASE_TAG = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_en,
    input  logic             push_en,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             cpop_en,
    input  logic             restore_en,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty,
    output logic             ready
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    fl_state_e        state_q, state_d;
    logic [PW-1:0]    head_q, tail_q, chead_q;
    logic [PW-1:0]    chead_d;
    logic [TAG_W-1:0] mem_q [DEPTH];
    logic             wr_en;
    logic [TAG_W-1:0] wr_tag;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_FILL: if (tail_q == PW'(DEPTH - 1)) state_d = FL_RUN;
            FL_RUN:  state_d = FL_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_FILL;
        else        state_q <= state_d;
    end

    // outputs and write selection per state
    always_comb begin
        ready  = 1'b0;
        wr_en  = 1'b0;
        wr_tag = push_tag;
        unique case (state_q)
            FL_FILL: begin
                wr_en  = 1'b1;
                wr_tag = TAG_W'(BASE_TAG) + TAG_W'(tail_q[IW-1:0]);
            end
            FL_RUN: begin
                ready = 1'b1;
                wr_en = push_en;
            end
        endcase
    end

    assign empty    = !ready || (head_q == tail_q);
    assign head_tag = mem_q[head_q[IW-1:0]];
    assign chead_d  = cpop_en ? chead_q + PW'(1) : chead_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[tail_q[IW-1:0]] <= wr_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            chead_q <= '0;
        end else begin
            if (wr_en) tail_q <= tail_q + PW'(1);
            chead_q <= chead_d;
            if (restore_en)  head_q <= chead_d;
            else if (pop_en) head_q <= head_q + PW'(1);
        end
    end

    // R5: never allocate from an empty list
    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> !empty)
        else $error("pop from empty free list");

    // R6: occupancy never exceeds the storage
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ((tail_q - head_q) <= PW'(DEPTH)))
        else $error("free list overflow");

    // R8: the commit checkpoint always sits exactly one storage depth behind the tail
    p_checkpoint_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ((tail_q - chead_q) == PW'(DEPTH)))
        else $error("commit checkpoint out of step with tail");

    // R1: no traffic while seeding
    p_quiet_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !(pop_en || push_en || cpop_en || restore_en))
        else $error("traffic during free-list seeding");
endmodule

// File: rtl/rn_rename_unit.sv
`timescale 1ns/1ps
module rn_rename_unit #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 48
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ren_valid,
    input  logic [$clog2(NUM_ARCH)-1:0]   ren_src1_arch,
    input  logic [$clog2(NUM_ARCH)-1:0]   ren_src2_arch,
    input  logic [$clog2(NUM_ARCH)-1:0]   ren_dst_arch,
    output logic [$clog2(NUM_PHYS)-1:0]   ren_src1_tag,
    output logic [$clog2(NUM_PHYS)-1:0]   ren_src2_tag,
    output logic [$clog2(NUM_PHYS)-1:0]   ren_dst_tag,
    output logic                          ren_stall,
    output logic                          ren_accept,
    input  logic                          ret_valid,
    input  logic [$clog2(NUM_ARCH)-1:0]   ret_dst_arch,
    input  logic [$clog2(NUM_PHYS)-1:0]   ret_dst_tag,
    input  logic                          flush
);
    localparam int AIDX_W     = $clog2(NUM_ARCH);
    localparam int TAG_W      = $clog2(NUM_PHYS);
    localparam int FREE_DEPTH = NUM_PHYS - NUM_ARCH;

    logic [NUM_ARCH-1:0][TAG_W-1:0] spec_img, cmt_img;
    logic [TAG_W-1:0]  fl_head;
    logic              fl_empty, fl_ready;
    logic              dst_nz, alloc, ret_wr;
    logic              spec_wr_en;
    logic [AIDX_W-1:0] spec_wr_idx;
    logic [TAG_W-1:0]  spec_wr_tag;

    assign dst_nz     = (ren_dst_arch != '0);
    assign ren_stall  = ren_valid && (!fl_ready || (dst_nz && fl_empty));
    assign ren_accept = ren_valid && !ren_stall && !flush;
    assign alloc      = ren_accept && dst_nz;
    assign ret_wr     = ret_valid && (ret_dst_arch != '0);

    assign ren_src1_tag = spec_img[ren_src1_arch];
    assign ren_src2_tag = spec_img[ren_src2_arch];
    assign ren_dst_tag  = dst_nz ? fl_head : '0;

    // On flush the speculative map loads the committed image and the
    // same-cycle retirement rides the write port on top of it.
    always_comb begin
        if (flush) begin
            spec_wr_en  = ret_wr;
            spec_wr_idx = ret_dst_arch;
            spec_wr_tag = ret_dst_tag;
        end else begin
            spec_wr_en  = alloc;
            spec_wr_idx = ren_dst_arch;
            spec_wr_tag = fl_head;
        end
    end

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .AIDX_W(AIDX_W)) u_spec_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (spec_wr_en),
        .wr_idx   (spec_wr_idx),
        .wr_tag   (spec_wr_tag),
        .load_en  (flush),
        .load_img (cmt_img),
        .img_q    (spec_img)
    );

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .AIDX_W(AIDX_W)) u_cmt_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ret_wr),
        .wr_idx   (ret_dst_arch),
        .wr_tag   (ret_dst_tag),
        .load_en  (1'b0),
        .load_img ('0),
        .img_q    (cmt_img)
    );

    rn_free_list #(.DEPTH(FREE_DEPTH), .TAG_W(TAG_W), .BASE_TAG(NUM_ARCH)) u_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_en     (alloc),
        .push_en    (ret_wr),
        .push_tag   (cmt_img[ret_dst_arch]),
        .cpop_en    (ret_wr),
        .restore_en (flush),
        .head_tag   (fl_head),
        .empty      (fl_empty),
        .ready      (fl_ready)
    );

    // R7: one cycle after a flush both maps agree
    p_flush_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (spec_img == cmt_img))
        else $error("speculative map differs from committed map after flush");

    // R9: a flush cycle never accepts a request
    p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !ren_accept)
        else $error("request accepted during flush");

    // R3: an accepted writer never receives tag 0
    p_dst_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_accept && dst_nz) |-> (ren_dst_tag != '0))
        else $error("writer allocated tag 0");

    // R5: a stall with no release or flush leaves the offered tag unchanged
    p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_stall && fl_ready && !ret_valid && !flush) |=> $stable(fl_head))
        else $error("free-list head moved during stall");

    // R4: register 0 always reads tag 0
    p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_src1_arch == '0) |-> (ren_src1_tag == '0))
        else $error("register 0 read a non-zero tag");
endmodule

// File: tb/test_rn_rename_unit.sv
`timescale 1ns/1ps
module test_rn_rename_unit;
    localparam int NA = 16;
    localparam int NP = 48;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ren_valid;
    logic [3:0] ren_src1_arch, ren_src2_arch, ren_dst_arch;
    logic [5:0] ren_src1_tag, ren_src2_tag, ren_dst_tag;
    logic       ren_stall, ren_accept;
    logic       ret_valid;
    logic [3:0] ret_dst_arch;
    logic [5:0] ret_dst_tag;
    logic       flush;

    always #5 clk = ~clk;

    rn_rename_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP)) i_rn_rename_unit (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_src1_arch(ren_src1_arch),
        .ren_src2_arch(ren_src2_arch), .ren_dst_arch(ren_dst_arch),
        .ren_src1_tag(ren_src1_tag), .ren_src2_tag(ren_src2_tag),
        .ren_dst_tag(ren_dst_tag), .ren_stall(ren_stall), .ren_accept(ren_accept),
        .ret_valid(ret_valid), .ret_dst_arch(ret_dst_arch),
        .ret_dst_tag(ret_dst_tag), .flush(flush)
    );

    typedef struct packed {
        logic       stall;
        logic       ok;
        logic [5:0] s1;
        logic [5:0] s2;
        logic [5:0] d;
        logic       chk_d;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    int    smap[NA];
    int    cmap[NA];
    int    fq[$];
    int    infl[$];
    int    rob_a[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    task automatic check(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
        end
    endtask

    // driver: applies one cycle of stimulus, pushes the expectation, updates the model
    task automatic step(string req, bit rv, int s1, int s2, int d, bit retv, bit fl);
        exp_t e;
        bit   do_ret;
        int   ra, rt;
        @(negedge clk);
        do_ret = retv && (rob_a.size() > 0);
        ren_valid     = rv;
        ren_src1_arch = 4'(s1);
        ren_src2_arch = 4'(s2);
        ren_dst_arch  = 4'(d);
        ret_valid     = do_ret;
        ret_dst_arch  = do_ret ? 4'(rob_a[0]) : 4'd0;
        ret_dst_tag   = do_ret ? 6'(infl[0]) : 6'd0;
        flush         = fl;

        e.stall = rv && (d != 0) && (fq.size() == 0);
        e.ok    = rv && !e.stall && !fl;
        e.s1    = 6'(smap[s1]);
        e.s2    = 6'(smap[s2]);
        e.d     = (d == 0) ? 6'd0 : ((fq.size() > 0) ? 6'(fq[0]) : 6'd0);
        e.chk_d = rv && !e.stall;
        exp_q.push_back(e);
        req_q.push_back(req);

        if (do_ret) begin
            ra = rob_a.pop_front();
            rt = infl.pop_front();
            fq.push_back(cmap[ra]);
            cmap[ra] = rt;
        end
        if (fl) begin
            for (int i = 0; i < NA; i++) smap[i] = cmap[i];
            fq = {infl, fq};
            infl.delete();
            rob_a.delete();
        end else if (e.ok && d != 0) begin
            rt = fq.pop_front();
            infl.push_back(rt);
            rob_a.push_back(d);
            smap[d] = rt;
        end
    endtask

    // monitor: compares outputs with expectations after inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (exp_q.size() > 0) begin
                exp_t  e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(r, "stall",  int'(ren_stall),    int'(e.stall));
                check(r, "accept", int'(ren_accept),   int'(e.ok));
                check(r, "src1",   int'(ren_src1_tag), int'(e.s1));
                check(r, "src2",   int'(ren_src2_tag), int'(e.s2));
                if (e.chk_d) check(r, "dst", int'(ren_dst_tag), int'(e.d));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired before end of run (R1..R9 incomplete)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NA; i++) begin smap[i] = i; cmap[i] = i; end
        for (int i = NA; i < NP; i++) fq.push_back(i);
        rst_n = 1'b0;
        ren_valid = 1'b1; ren_src1_arch = 4'd0; ren_src2_arch = 4'd0; ren_dst_arch = 4'd1;
        ret_valid = 1'b0; ret_dst_arch = 4'd0; ret_dst_tag = 6'd0; flush = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: stall while seeding, even for a destination-0 request
        @(negedge clk); #3;
        check("R1", "stall during seed", int'(ren_stall), 1);
        ren_dst_arch = 4'd0;
        #1;
        check("R1", "stall during seed dst0", int'(ren_stall), 1);
        check("R1", "accept during seed", int'(ren_accept), 0);
        ren_valid = 1'b0;
        repeat (40) @(negedge clk);

        // R1: identity map after seeding
        for (int i = 0; i < NA; i++) step("R1", 1, i, (i + 1) % NA, 0, 0, 0);
        // R2 R3: FIFO-ordered allocation, same-cycle source sees old tag
        for (int i = 1; i <= 5; i++) step("R3", 1, i, i, i, 0, 0);
        step("R2", 1, 3, 5, 7, 0, 0);
        step("R2", 1, 7, 6, 0, 0, 0);
        // R6: retire two writers
        step("R6", 0, 0, 0, 0, 1, 0);
        step("R6", 0, 0, 0, 0, 1, 0);
        // R7 R8: flush, then read committed state and reallocate
        step("R7", 0, 0, 0, 0, 0, 1);
        step("R7", 1, 1, 4, 0, 0, 0);
        step("R7", 1, 2, 7, 0, 0, 0);
        step("R8", 1, 0, 0, 9, 0, 0);
        step("R8", 1, 9, 0, 10, 0, 0);
        // R4: register 0 destination allocates nothing
        step("R4", 1, 0, 0, 0, 0, 0);
        step("R4", 1, 9, 0, 11, 0, 0);
        // R5: drain the free list until stall
        for (int i = 0; i < 40; i++) step("R5", 1, 1, 2, 3, 0, 0);
        step("R4", 1, 0, 3, 0, 0, 0);
        // R6: retire while stalled, freed tag then allocated
        step("R6", 1, 1, 2, 3, 1, 0);
        step("R6", 1, 1, 2, 3, 0, 0);
        step("R5", 1, 1, 2, 3, 0, 0);
        // R9: flush with a request in the same cycle
        step("R9", 1, 1, 1, 5, 0, 1);
        step("R9", 1, 5, 3, 0, 0, 0);
        // R7: flush together with a retirement
        for (int i = 0; i < 4; i++) step("R7", 1, i, i + 1, i + 2, 0, 0);
        step("R7", 0, 0, 0, 0, 1, 1);
        step("R7", 1, 2, 3, 4, 0, 0);
        step("R8", 1, 4, 5, 6, 0, 0);
        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            bit rv, rt, fl;
            rv = ($urandom % 4) != 0;
            rt = ($urandom % 2) == 0;
            fl = ($urandom % 40) == 0;
            step("R2", rv, int'($urandom % NA), int'($urandom % NA),
                 int'($urandom % NA), rt, fl);
        end
        step("R9", 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule